// File: doc/BRIEF.md
# Reset Release Sequencer

This block decides when a microcontroller core may leave reset. It takes digital threshold indicators in place of analog levels. `porOk` goes high once the supply has reached its power-on level. `belowBor` is high while the supply sits under the brown-out threshold. It also takes configuration bits, a slow timebase tick and a wake request. All sequencing runs on the oscillator clock `clk`, and the block drives a single reset output, `rstOut`. It also keeps sticky flags that record whether the last reset came from power-on or from brown-out.

After power-on or a brown-out, the sequencer holds reset until the supply indicator is clear. It then runs an optional power-up delay, counted in timebase ticks. In crystal clock modes, after a power-on, it follows this with an oscillator start-up count of `clk` cycles. The brown-out input is filtered, so only a dip that lasts a minimum number of cycles causes a reset. A dip that qualifies while the power-up delay is running sends the sequencer back to hold. The delay then starts again from zero. A wake request in a crystal mode runs only the oscillator count.

Top module: `reset_release_seq`

## Requirements
- R1: While `porOk` is low, `rstOut` and `porFlag` are 1 and `borFlag` is 0, without waiting for a clock. `porOk` passes through a two-flop synchronizer before the sequencer may leave hold.
- R2: With `pwrtOff`=1 the power-up delay is skipped. With `pwrtOff`=0 the delay ends on the `PWRT_TICKS`-th one-cycle `tickIn` pulse seen after hold ends. In mode 0, `rstOut` falls one clock after that tick is sampled.
- R3: `rstOut` stays 1 for as long as the power-up delay or the oscillator count is running.
- R4: `oscMode` encodes the clock mode: 0 = external clock, 1 = low-power crystal, 2 = standard crystal, 3 = high-speed crystal. After a power-on in modes 1 to 3, release waits a further `OST_CYCLES` clocks. Release then comes `OST_CYCLES`+1 clocks after the last tick, or 3+`OST_CYCLES` clocks after `porOk` rises when the delay is off.
- R5: With `borEn`=1, `belowBor` held for `BOR_FILT` or more clocks raises `rstOut` and sets `borFlag`. Shorter dips have no effect. With `borEn`=0, `belowBor` is ignored.
- R6: After a brown-out, reset holds until `belowBor` is low. The power-up delay then runs, and the oscillator count is never added, whatever the mode.
- R7: A qualifying dip during the power-up delay returns the sequencer to hold. After recovery, a full `PWRT_TICKS` ticks are needed again.
- R8: A one-cycle `wakeReq` while running in modes 1 to 3 asserts `rstOut` for exactly `OST_CYCLES` clocks. In mode 0 it is ignored.
- R9: A `statClr` pulse clears `porFlag` and `borFlag` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; sequencing and reset release |
| porOk | input | 1 | Power-on level reached (async, low acts as reset) |
| belowBor | input | 1 | Supply under brown-out threshold (async) |
| borEn | input | 1 | Brown-out detection enable, active high |
| pwrtOff | input | 1 | Power-up delay disable, active high |
| oscMode | input | 2 | Clock mode: 0 external, 1-3 crystal |
| tickIn | input | 1 | Slow timebase tick, one-cycle pulse |
| wakeReq | input | 1 | Wake-from-sleep request, one-cycle pulse |
| statClr | input | 1 | Clears both cause flags |
| rstOut | output | 1 | Internal reset, active high |
| porFlag | output | 1 | Last reset was power-on |
| borFlag | output | 1 | A brown-out reset occurred |

## Verification
The bench sweeps all four clock modes against both power-up delay settings and measures the exact release cycle. This separates the timer-only path, the oscillator-only path, the chained path and the immediate path. Brown-out dips one cycle shorter than the filter length, and far longer than it, show where the filter threshold lies. Dips are also applied with detection disabled. A long dip during the delay, followed by one tick short of a full count, shows that the timer restarts and that the oscillator count is not added after a brown-out. Wake pulses in crystal and external modes show that the wake-only count applies only to crystal modes.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    CLK_EXT    = 2'd0,
    CLK_LOWPWR = 2'd1,
    CLK_XTAL   = 2'd2,
    CLK_FAST   = 2'd3
  } clkMode_e;

  typedef struct packed {
    logic pwrtRun;
    logic ostRun;
    logic setBor;
  } seqCtl_t;

  typedef struct packed {
    logic porReady;
    logic supplyLow;
    logic borTrip;
    logic pwrtDone;
    logic ostDone;
  } seqStat_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024,
  parameter int BOR_FILT   = 8
) (
  input  logic     clk,
  input  logic     porOk,
  input  logic     belowBor,
  input  logic     borEn,
  input  logic     tickIn,
  input  logic     statClr,
  input  seqCtl_t  ctl,
  output seqStat_t stat,
  output logic     porFlag,
  output logic     borFlag
);
  localparam int PW = $clog2(PWRT_TICKS + 1);
  localparam int OW = $clog2(OST_CYCLES);
  localparam int FW = $clog2(BOR_FILT + 1);

  logic          porSyncQ, borSyncQ, lowEff;
  logic [PW-1:0] pwrtCnt;
  logic [OW-1:0] ostCnt;
  logic [FW-1:0] filtCnt;

  // two-flop synchronizers, one per asynchronous threshold input
  logic [1:0] syncIn, syncOut;
  assign syncIn = {belowBor, 1'b1};
  for (genvar i = 0; i < 2; i++) begin : g_sync
    rstseq_sync #(.STAGES(2)) u_sync (
      .clk(clk), .arstN(porOk), .d(syncIn[i]), .q(syncOut[i])
    );
  end
  assign porSyncQ = syncOut[0];
  assign borSyncQ = syncOut[1];
  assign lowEff   = borEn & borSyncQ;

  // brown-out duration filter, saturating
  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk)                       filtCnt <= '0;
    else if (!lowEff)                 filtCnt <= '0;
    else if (filtCnt != FW'(BOR_FILT)) filtCnt <= filtCnt + 1'b1;
  end

  // power-up delay, counted in timebase ticks
  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk)                                 pwrtCnt <= '0;
    else if (!ctl.pwrtRun)                      pwrtCnt <= '0;
    else if (tickIn && !stat.pwrtDone)          pwrtCnt <= pwrtCnt + 1'b1;
  end

  // oscillator start-up count, one per clock
  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk)           ostCnt <= '0;
    else if (!ctl.ostRun) ostCnt <= '0;
    else                  ostCnt <= ostCnt + 1'b1;
  end

  // sticky cause flags
  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk) begin
      porFlag <= 1'b1;
      borFlag <= 1'b0;
    end else begin
      if (statClr) porFlag <= 1'b0;
      if (ctl.setBor)   borFlag <= 1'b1;
      else if (statClr) borFlag <= 1'b0;
    end
  end

  assign stat.porReady  = porSyncQ;
  assign stat.supplyLow = lowEff;
  assign stat.borTrip   = (filtCnt == FW'(BOR_FILT));
  assign stat.pwrtDone  = (pwrtCnt == PW'(PWRT_TICKS));
  assign stat.ostDone   = (ostCnt == OW'(OST_CYCLES - 1));
endmodule

// File: rtl/rstseq_control.sv
module rstseq_control
  import rstseq_pkg::*;
(
  input  logic     clk,
  input  logic     porOk,
  input  logic     pwrtOff,
  input  logic [1:0] oscMode,
  input  logic     wakeReq,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     rstOut
);
  typedef enum logic [1:0] {ST_HOLD, ST_PWRT, ST_OST, ST_RUN} seqState_e;

  seqState_e state, stateNext;
  logic      causeOst, xtalMode, ostWanted, tripNow;

  assign xtalMode  = clkMode_e'(oscMode) != CLK_EXT;
  assign ostWanted = xtalMode && causeOst;

  always_comb begin
    stateNext = state;
    tripNow   = 1'b0;
    unique case (state)
      ST_HOLD:
        if (stat.porReady && !stat.supplyLow)
          stateNext = !pwrtOff ? ST_PWRT : (ostWanted ? ST_OST : ST_RUN);
      ST_PWRT:
        if (stat.borTrip) tripNow = 1'b1;
        else if (stat.pwrtDone) stateNext = ostWanted ? ST_OST : ST_RUN;
      ST_OST:
        if (stat.borTrip) tripNow = 1'b1;
        else if (stat.ostDone) stateNext = ST_RUN;
      ST_RUN:
        if (stat.borTrip) tripNow = 1'b1;
        else if (wakeReq && xtalMode) stateNext = ST_OST;
      default: stateNext = ST_HOLD;
    endcase
    if (tripNow) stateNext = ST_HOLD;
  end

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk) begin
      state    <= ST_HOLD;
      rstOut   <= 1'b1;
      causeOst <= 1'b1;
    end else begin
      state  <= stateNext;
      rstOut <= (stateNext != ST_RUN);
      if (tripNow) causeOst <= 1'b0;
    end
  end

  assign ctl.pwrtRun = (state == ST_PWRT);
  assign ctl.ostRun  = (state == ST_OST);
  assign ctl.setBor  = tripNow;
endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
  import rstseq_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024,
  parameter int BOR_FILT   = 8
) (
  input  logic       clk,
  input  logic       porOk,
  input  logic       belowBor,
  input  logic       borEn,
  input  logic       pwrtOff,
  input  logic [1:0] oscMode,
  input  logic       tickIn,
  input  logic       wakeReq,
  input  logic       statClr,
  output logic       rstOut,
  output logic       porFlag,
  output logic       borFlag
);
  seqCtl_t  ctlBus;
  seqStat_t statBus;

  rstseq_datapath #(
    .PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES), .BOR_FILT(BOR_FILT)
  ) u_dp (
    .clk(clk), .porOk(porOk), .belowBor(belowBor), .borEn(borEn),
    .tickIn(tickIn), .statClr(statClr), .ctl(ctlBus), .stat(statBus),
    .porFlag(porFlag), .borFlag(borFlag)
  );

  rstseq_control u_ctl (
    .clk(clk), .porOk(porOk), .pwrtOff(pwrtOff), .oscMode(oscMode),
    .wakeReq(wakeReq), .stat(statBus), .ctl(ctlBus), .rstOut(rstOut)
  );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic       clk,
  input logic       porOk,
  input logic       borEn,
  input logic       pwrtOff,
  input logic [1:0] oscMode,
  input logic       statClr,
  input logic       rstOut,
  input logic       porFlag,
  input logic       borFlag,
  input logic       pwrtRun,
  input logic       ostRun
);
  AST_POR_FLAG_ONLY_RESET: assert property (@(posedge clk) disable iff (!porOk)
    !$rose(porFlag)); // R1
  AST_PWRT_DISABLED: assert property (@(posedge clk) disable iff (!porOk)
    $rose(pwrtRun) |-> !$past(pwrtOff)); // R2
  AST_HELD_WHILE_TIMING: assert property (@(posedge clk) disable iff (!porOk)
    (pwrtRun || ostRun) |-> rstOut); // R3
  AST_OST_XTAL_ONLY: assert property (@(posedge clk) disable iff (!porOk)
    $rose(ostRun) |-> ($past(oscMode) != 2'd0)); // R4
  AST_BOR_NEEDS_EN: assert property (@(posedge clk) disable iff (!porOk)
    $rose(borFlag) |-> $past(borEn)); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!porOk)
    statClr |=> !porFlag); // R9
endmodule

bind reset_release_seq rstseq_checker u_chk (
  .clk(clk), .porOk(porOk), .borEn(borEn), .pwrtOff(pwrtOff),
  .oscMode(oscMode), .statClr(statClr), .rstOut(rstOut),
  .porFlag(porFlag), .borFlag(borFlag),
  .pwrtRun(ctlBus.pwrtRun), .ostRun(ctlBus.ostRun)
);

// File: tb/reset_release_seq_test.sv
`timescale 1ns/1ps
module reset_release_seq_test;
  localparam int P = 5;
  localparam int N = 16;
  localparam int F = 4;

  logic clk = 1'b0;
  logic porOk = 1'b0, belowBor = 1'b0, borEn = 1'b1, pwrtOff = 1'b0;
  logic [1:0] oscMode = 2'd0;
  logic tickIn = 1'b0, wakeReq = 1'b0, statClr = 1'b0;
  logic rstOut, porFlag, borFlag;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  reset_release_seq #(.PWRT_TICKS(P), .OST_CYCLES(N), .BOR_FILT(F)) uut (
    .clk(clk), .porOk(porOk), .belowBor(belowBor), .borEn(borEn),
    .pwrtOff(pwrtOff), .oscMode(oscMode), .tickIn(tickIn),
    .wakeReq(wakeReq), .statClr(statClr), .rstOut(rstOut),
    .porFlag(porFlag), .borFlag(borFlag)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) tickIn = 1'b1;
    @(negedge clk) tickIn = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!rstOut) break;
    end
  endtask

  task automatic powerCycle(input logic [1:0] m, input logic off);
    @(negedge clk);
    porOk = 1'b0; oscMode = m; pwrtOff = off; belowBor = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset while porOk low", {rstOut, porFlag, borFlag}, 3'b110);
    porOk = 1'b1;
  endtask

  initial begin
    int n;
    // sweep every mode against both delay settings
    for (int m = 0; m < 4; m++) begin
      for (int off = 0; off < 2; off++) begin
        powerCycle(2'(m), 1'(off));
        if (off == 1) begin
          measure(n);
          check(m == 0 ? "R2 skipped delay" : "R4 oscillator count after por", n, 3 + (m != 0 ? N : 0));
        end else begin
          repeat (6) @(negedge clk);
          check("R3 held before ticks", rstOut, 1);
          for (int t = 0; t < P - 1; t++) begin tickOnce(); @(negedge clk); end
          check("R2 held one tick short", rstOut, 1);
          tickOnce();
          measure(n);
          check(m == 0 ? "R2 release after ticks" : "R4 release after ticks plus oscillator", n, 1 + (m != 0 ? N : 0));
        end
      end
    end
    // now running, mode 3, delay off
    check("R9 porFlag set before clear", porFlag, 1);
    @(negedge clk) statClr = 1'b1;
    @(negedge clk) statClr = 1'b0;
    check("R9 porFlag cleared", porFlag, 0);

    // wake in crystal mode
    @(negedge clk) wakeReq = 1'b1;
    @(negedge clk) wakeReq = 1'b0;
    check("R8 wake asserts reset", rstOut, 1);
    measure(n);
    check("R8 wake count length", n, N);
    // wake in external mode is ignored
    oscMode = 2'd0;
    @(negedge clk) wakeReq = 1'b1;
    @(negedge clk) wakeReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 wake ignored in external mode", rstOut, 0);

    // short dip, one cycle under the filter length
    @(negedge clk) belowBor = 1'b1;
    repeat (F - 1) @(negedge clk);
    belowBor = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 short dip ignored", {rstOut, borFlag}, 0);
    // long dip with detection disabled
    borEn = 1'b0;
    belowBor = 1'b1;
    repeat (4 * F) @(negedge clk);
    belowBor = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 dip ignored when disabled", {rstOut, borFlag}, 0);
    borEn = 1'b1;

    // long dip from run, crystal mode, delay on
    oscMode = 2'd2; pwrtOff = 1'b0;
    belowBor = 1'b1;
    repeat (3 * F) @(negedge clk);
    check("R5 long dip resets", {rstOut, borFlag}, 2'b11);
    for (int t = 0; t < P + 1; t++) begin tickOnce(); @(negedge clk); end
    check("R6 held while supply low", rstOut, 1);
    belowBor = 1'b0;
    repeat (6) @(negedge clk);
    for (int t = 0; t < 3; t++) begin tickOnce(); @(negedge clk); end
    // dip during the delay
    belowBor = 1'b1;
    repeat (3 * F) @(negedge clk);
    belowBor = 1'b0;
    repeat (6) @(negedge clk);
    for (int t = 0; t < P - 1; t++) begin tickOnce(); @(negedge clk); end
    repeat (3) @(negedge clk);
    check("R7 timer restarted after dip", rstOut, 1);
    tickOnce();
    measure(n);
    check("R6 no oscillator count after brown-out", n, 1);
    @(negedge clk) statClr = 1'b1;
    @(negedge clk) statClr = 1'b0;
    check("R9 flags cleared", {porFlag, borFlag}, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule